// File: doc/BRIEF.md
# Drive Seek and Interrupt Status Unit

This unit keeps the head position of up to four disk drives and answers the controller's interrupt polling. A command strobe carries an operation code, a drive number, a head bit and an 8-bit argument. The argument is a target track for an absolute seek, or a step count for a relative move. Every positioning command updates the selected drive's present-track register in one cycle and raises the interrupt line. The unit also records a status-0 byte that describes the outcome.

A sense command drops the interrupt line and returns a response of two bytes: status 0 and the present track of the currently selected drive. After a controller reset the unit raises the interrupt and expects one poll per drive. Each of these polls returns its own ready-changed code. Any later interrupt cuts that polling sequence short. A neighbouring unit can also raise the interrupt with a status byte of its own, for example an equipment fault. A sense command then returns that byte unchanged.

Top module: `seek_sense_unit`

## Requirements
- R1: After `rst_n` is released, `irq_o` and `rsp_valid_o` are low, `st0_o` is 0xC0 and every present track is 0.
- R2: A `ctl_reset_i` pulse sets `irq_o`, loads `st0_o` with 0xC0, clears every present track and selects drive 0 with head 0. The next four sense commands return 0xC0, 0xC1, 0xC2 and 0xC3 in that order, each with the present track of drive 0.
- R3: Once the poll counter is zero, a sense command returns 0x20 | head<<2 | drive, taken from the last positioning command. After any sense, `st0_o` reads 0xC0.
- R4: Operation codes are 0 seek, 1 recalibrate, 2 step outward, 3 step inward and 4 sense. Any accepted command clears `irq_o`, and a sense leaves it low. Codes 5 to 7 are ignored and leave `irq_o` unchanged.
- R5: A seek whose target is at or below the drive's maximum track sets the present track to the target, sets `irq_o` and loads `st0_o` with 0x20.
- R6: A seek whose target is above the drive's maximum leaves the present track unchanged, sets `irq_o` and loads `st0_o` with 0x60 (abnormal termination 0x40 plus seek-end 0x20).
- R7: A recalibrate sets the present track to 0 and loads `st0_o` with 0x20 | drive.
- R8: A step outward adds the count to the track. When the sum reaches or passes the maximum, the track becomes maximum − 1 (or 0 if the maximum is 0). `st0_o` becomes 0x20.
- R9: A step inward subtracts the count. When the count exceeds the track, the track becomes 0. `st0_o` becomes 0x20.
- R10: Any interrupt raise clears the post-reset poll counter, so the next sense returns the seek-end form.
- R11: An external raise (`ext_raise_i` while no command or controller reset is present) sets `irq_o` and latches `ext_st0_i`. If that byte has the equipment-check bit 0x10 set, the next sense returns it unchanged.
- R12: `irq_o` changes only in the cycle after a controller reset, a command or a raise.
- R13: The response appears on the cycle after the sense strobe, with `rsp_valid_o` high for one cycle and `rsp_track_o` holding the present track of the selected drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_reset_i | input | 1 | Controller reset with interrupt |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 3 | Operation code |
| cmd_drive_i | input | 2 | Drive number |
| cmd_head_i | input | 1 | Head select |
| cmd_arg_i | input | 8 | Target track or step count |
| max_track_i | input | 32 | Maximum track per drive, drive 0 in the low byte |
| ext_raise_i | input | 1 | Raise interrupt with an external status byte |
| ext_st0_i | input | 8 | External status byte |
| irq_o | output | 1 | Interrupt pending |
| st0_o | output | 8 | Latched status 0 |
| rsp_valid_o | output | 1 | Sense response strobe |
| rsp_st0_o | output | 8 | Status 0 returned by sense |
| rsp_track_o | output | 8 | Present track returned by sense |

## Verification
The hardest state to reach is a post-reset polling sequence that a raise cuts off partway through. The stimulus issues a controller reset and one poll. It then sends an inward step of zero to a drive whose track was moved before the reset, which must read 0 now. The next poll must show the seek-end form instead of 0xC1. The equipment-check return path is reached only through the external raise input, so the bench checks that the fault byte is returned exactly once.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [2:0] {
    OP_SEEK     = 3'd0,
    OP_RECAL    = 3'd1,
    OP_STEP_OUT = 3'd2,
    OP_STEP_IN  = 3'd3,
    OP_SENSE    = 3'd4
  } ssu_op_e;

  localparam logic [7:0] ST0_SEEK_END  = 8'h20;
  localparam logic [7:0] ST0_EQUIP     = 8'h10;
  localparam logic [7:0] ST0_ABNORMAL  = 8'h40;
  localparam logic [7:0] ST0_READY_CHG = 8'hC0;
endpackage

// File: rtl/ssu_step_calc.sv
module ssu_step_calc
  import ssu_pkg::*;
#(
  parameter int TRK_W = 8,
  parameter int DRV_W = 2
) (
  input  logic [2:0]       op_i,
  input  logic [DRV_W-1:0] drive_i,
  input  logic [TRK_W-1:0] arg_i,
  input  logic [TRK_W-1:0] cur_i,
  input  logic [TRK_W-1:0] max_i,
  output logic [TRK_W-1:0] nxt_o,
  output logic [7:0]       st0_o
);
  logic [TRK_W:0] sum;

  always_comb begin
    sum   = {1'b0, cur_i} + {1'b0, arg_i};
    nxt_o = cur_i;
    st0_o = ST0_SEEK_END;
    case (op_i)
      OP_SEEK: begin
        if (arg_i > max_i) st0_o = ST0_ABNORMAL | ST0_SEEK_END;
        else               nxt_o = arg_i;
      end
      OP_RECAL: begin
        nxt_o = '0;
        st0_o = ST0_SEEK_END | 8'(drive_i);
      end
      OP_STEP_OUT: begin
        if (sum >= {1'b0, max_i}) nxt_o = (max_i == '0) ? '0 : max_i - 1'b1;
        else                      nxt_o = sum[TRK_W-1:0];
      end
      OP_STEP_IN: begin
        if (arg_i > cur_i) nxt_o = '0;
        else               nxt_o = cur_i - arg_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ssu_track_bank.sv
module ssu_track_bank #(
  parameter int NUM_DRIVES = 4,
  parameter int TRK_W      = 8,
  parameter int DRV_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all_i,
  input  logic             wr_en_i,
  input  logic [DRV_W-1:0] wr_sel_i,
  input  logic [TRK_W-1:0] wr_val_i,
  output logic [TRK_W-1:0] trk_o [NUM_DRIVES]
);
  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_lane
    logic [TRK_W-1:0] trk_q, trk_d;
    logic             trk_en;

    always_comb begin
      trk_en = clr_all_i || (wr_en_i && (wr_sel_i == DRV_W'(g)));
      trk_d  = clr_all_i ? '0 : wr_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      trk_q <= '0;
      else if (trk_en) trk_q <= trk_d;
    end

    assign trk_o[g] = trk_q;

    p_clear_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all_i |=> (trk_q == '0));
  end
endmodule

// File: rtl/ssu_irq_latch.sv
module ssu_irq_latch
  import ssu_pkg::*;
#(
  parameter int POLL_COUNT = 4,
  parameter int CNT_W      = $clog2(POLL_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_reset_i,
  input  logic             cmd_start_i,
  input  logic             sense_take_i,
  input  logic             raise_i,
  input  logic [7:0]       raise_st0_i,
  output logic             pend_o,
  output logic [7:0]       latch_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             pend_q, pend_d;
  logic [7:0]       latch_q, latch_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    pend_d  = pend_q;
    latch_d = latch_q;
    cnt_d   = cnt_q;
    if (ctl_reset_i) begin
      pend_d  = 1'b1;
      latch_d = ST0_READY_CHG;
      cnt_d   = CNT_W'(POLL_COUNT);
    end else begin
      if (cmd_start_i) pend_d = 1'b0;
      if (sense_take_i) begin
        latch_d = ST0_READY_CHG;
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      end
      if (raise_i) begin
        pend_d  = 1'b1;
        latch_d = raise_st0_i;
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      latch_q <= ST0_READY_CHG;
      cnt_q   <= '0;
    end else begin
      pend_q  <= pend_d;
      latch_q <= latch_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pend_o  = pend_q;
  assign latch_o = latch_q;
  assign cnt_o   = cnt_q;

  p_irq_on_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pend_q) |-> $past(ctl_reset_i || cmd_start_i || raise_i));
  p_reset_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset_i |=> (pend_q && latch_q == ST0_READY_CHG && cnt_q == CNT_W'(POLL_COUNT)));
  p_raise_clears_poll_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i && !ctl_reset_i) |=> (cnt_q == '0 && pend_q));
  p_poll_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(POLL_COUNT));
endmodule

// File: rtl/seek_sense_unit.sv
module seek_sense_unit
  import ssu_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int TRK_W      = 8,
  parameter int POLL_COUNT = 4,
  localparam int DRV_W     = $clog2(NUM_DRIVES),
  localparam int CNT_W     = $clog2(POLL_COUNT + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ctl_reset_i,
  input  logic                        cmd_valid_i,
  input  logic [2:0]                  cmd_op_i,
  input  logic [DRV_W-1:0]            cmd_drive_i,
  input  logic                        cmd_head_i,
  input  logic [TRK_W-1:0]            cmd_arg_i,
  input  logic [NUM_DRIVES*TRK_W-1:0] max_track_i,
  input  logic                        ext_raise_i,
  input  logic [7:0]                  ext_st0_i,
  output logic                        irq_o,
  output logic [7:0]                  st0_o,
  output logic                        rsp_valid_o,
  output logic [7:0]                  rsp_st0_o,
  output logic [TRK_W-1:0]            rsp_track_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic             is_step, is_sense, cmd_start, raise;
  logic [7:0]       raise_st0, calc_st0, sense_st0, latch;
  logic [TRK_W-1:0] max_sel, cur_cmd, calc_nxt, sense_trk;
  logic [TRK_W-1:0] trk [NUM_DRIVES];
  logic [CNT_W-1:0] poll_cnt;
  logic [DRV_W-1:0] drv_q, drv_d;
  logic             head_q, head_d;
  logic             rsp_valid_q;
  logic [7:0]       rsp_st0_q;
  logic [TRK_W-1:0] rsp_trk_q;

  always_comb begin
    is_step   = cmd_valid_i && !ctl_reset_i && (cmd_op_i <= OP_STEP_IN);
    is_sense  = cmd_valid_i && !ctl_reset_i && (cmd_op_i == OP_SENSE);
    cmd_start = is_step || is_sense;
    raise     = is_step || (ext_raise_i && !cmd_valid_i && !ctl_reset_i);
    raise_st0 = is_step ? calc_st0 : ext_st0_i;
    max_sel   = max_track_i[cmd_drive_i*TRK_W +: TRK_W];
    cur_cmd   = trk[cmd_drive_i];
    sense_trk = trk[drv_q];
    if (poll_cnt != '0)
      sense_st0 = ST0_READY_CHG + 8'(POLL_COUNT - int'(poll_cnt));
    else if ((latch & ST0_EQUIP) != 8'h00)
      sense_st0 = latch;
    else
      sense_st0 = ST0_SEEK_END | {5'b0, head_q, 2'b00} | 8'(drv_q);
    drv_d  = ctl_reset_i ? '0 : cmd_drive_i;
    head_d = ctl_reset_i ? 1'b0 : cmd_head_i;
  end

  ssu_step_calc #(.TRK_W(TRK_W), .DRV_W(DRV_W)) u_calc (
    .op_i(cmd_op_i), .drive_i(cmd_drive_i), .arg_i(cmd_arg_i),
    .cur_i(cur_cmd), .max_i(max_sel), .nxt_o(calc_nxt), .st0_o(calc_st0)
  );

  ssu_track_bank #(.NUM_DRIVES(NUM_DRIVES), .TRK_W(TRK_W), .DRV_W(DRV_W)) u_bank (
    .clk(clk), .rst_n(rst_core_n), .clr_all_i(ctl_reset_i), .wr_en_i(is_step),
    .wr_sel_i(cmd_drive_i), .wr_val_i(calc_nxt), .trk_o(trk)
  );

  ssu_irq_latch #(.POLL_COUNT(POLL_COUNT), .CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst_n(rst_core_n), .ctl_reset_i(ctl_reset_i),
    .cmd_start_i(cmd_start), .sense_take_i(is_sense), .raise_i(raise),
    .raise_st0_i(raise_st0), .pend_o(irq_o), .latch_o(latch), .cnt_o(poll_cnt)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      drv_q       <= '0;
      head_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_st0_q   <= '0;
      rsp_trk_q   <= '0;
    end else begin
      rsp_valid_q <= is_sense;
      if (is_step || ctl_reset_i) begin
        drv_q  <= drv_d;
        head_q <= head_d;
      end
      if (is_sense) begin
        rsp_st0_q <= sense_st0;
        rsp_trk_q <= sense_trk;
      end
    end
  end

  assign st0_o       = latch;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_st0_o   = rsp_st0_q;
  assign rsp_track_o = rsp_trk_q;

  p_seek_oor_keep_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (is_step && cmd_op_i == OP_SEEK && cmd_arg_i > max_sel)
      |-> (calc_nxt == cur_cmd && calc_st0 == (ST0_ABNORMAL | ST0_SEEK_END)));
  p_step_out_below_max_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (is_step && cmd_op_i == OP_STEP_OUT && max_sel != '0) |-> (calc_nxt < max_sel));
  p_recal_zero_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (is_step && cmd_op_i == OP_RECAL) |=> (trk[$past(cmd_drive_i)] == '0));
  p_sense_drops_irq_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    is_sense |=> !irq_o);
endmodule

// File: tb/seek_sense_unit_tb.sv
module seek_sense_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        ctl_reset_i = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_op_i = 3'd0;
  logic [1:0]  cmd_drive_i = 2'd0;
  logic        cmd_head_i = 1'b0;
  logic [7:0]  cmd_arg_i = 8'd0;
  logic [31:0] max_track_i = {8'd0, 8'd10, 8'd39, 8'd79};
  logic        ext_raise_i = 1'b0;
  logic [7:0]  ext_st0_i = 8'd0;
  logic        irq_o, rsp_valid_o;
  logic [7:0]  st0_o, rsp_st0_o, rsp_track_o;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  seek_sense_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_reset_i(ctl_reset_i), .cmd_valid_i(cmd_valid_i),
    .cmd_op_i(cmd_op_i), .cmd_drive_i(cmd_drive_i), .cmd_head_i(cmd_head_i),
    .cmd_arg_i(cmd_arg_i), .max_track_i(max_track_i), .ext_raise_i(ext_raise_i),
    .ext_st0_i(ext_st0_i), .irq_o(irq_o), .st0_o(st0_o), .rsp_valid_o(rsp_valid_o),
    .rsp_st0_o(rsp_st0_o), .rsp_track_o(rsp_track_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] drv,
                       input logic head, input logic [7:0] arg);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_drive_i = drv;
    cmd_head_i = head; cmd_arg_i = arg;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic sense(input string req, input int exp_st0, input int exp_trk);
    issue(3'd4, 2'd0, 1'b0, 8'd0);
    chk({req, " rsp_valid"}, int'(rsp_valid_o), 1);
    chk({req, " st0"}, int'(rsp_st0_o), exp_st0);
    chk({req, " track"}, int'(rsp_track_o), exp_trk);
    chk({req, " irq low after sense R4"}, int'(irq_o), 0);
    @(negedge clk);
    chk("R13 rsp_valid one cycle", int'(rsp_valid_o), 0);
  endtask

  task automatic ctl_reset();
    @(negedge clk); ctl_reset_i = 1'b1;
    @(negedge clk); ctl_reset_i = 1'b0;
  endtask

  task automatic t_hw_reset();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 rsp_valid", int'(rsp_valid_o), 0);
    chk("R1 st0", int'(st0_o), 'hC0);
    sense("R1 track zero", 'h20, 0);
  endtask

  task automatic t_ctl_reset();
    issue(3'd0, 2'd0, 1'b0, 8'd7);
    ctl_reset();
    chk("R2 irq", int'(irq_o), 1);
    chk("R2 st0", int'(st0_o), 'hC0);
    issue(3'd7, 2'd0, 1'b0, 8'd0);
    chk("R4 code 7 ignored irq", int'(irq_o), 1);
    chk("R4 code 7 no response", int'(rsp_valid_o), 0);
    for (int i = 0; i < 4; i++) sense("R2 poll", 'hC0 + i, 0);
    sense("R3 after polls", 'h20, 0);
    chk("R3 latch back to C0", int'(st0_o), 'hC0);
  endtask

  task automatic t_seek();
    issue(3'd0, 2'd1, 1'b1, 8'd20);
    chk("R5 irq", int'(irq_o), 1);
    chk("R5 st0", int'(st0_o), 'h20);
    sense("R5 R13 seek", 'h25, 20);
    issue(3'd0, 2'd1, 1'b0, 8'd39);
    sense("R5 seek to max", 'h21, 39);
    issue(3'd0, 2'd1, 1'b0, 8'd20);
    issue(3'd0, 2'd1, 1'b0, 8'd40);
    chk("R6 irq", int'(irq_o), 1);
    chk("R6 st0", int'(st0_o), 'h60);
    sense("R6 track kept", 'h21, 20);
  endtask

  task automatic t_recal();
    issue(3'd1, 2'd1, 1'b0, 8'd0);
    chk("R7 st0", int'(st0_o), 'h21);
    chk("R7 irq", int'(irq_o), 1);
    sense("R7 track zero", 'h21, 0);
  endtask

  task automatic t_step();
    issue(3'd2, 2'd2, 1'b0, 8'd4);
    chk("R8 st0", int'(st0_o), 'h20);
    sense("R8 add", 'h22, 4);
    issue(3'd2, 2'd2, 1'b0, 8'd6);
    sense("R8 clamp", 'h22, 9);
    issue(3'd3, 2'd2, 1'b0, 8'd3);
    chk("R9 st0", int'(st0_o), 'h20);
    sense("R9 subtract", 'h22, 6);
    issue(3'd3, 2'd2, 1'b0, 8'd7);
    sense("R9 clamp", 'h22, 0);
    issue(3'd2, 2'd3, 1'b0, 8'd5);
    sense("R8 zero max", 'h23, 0);
  endtask

  task automatic t_ext();
    @(negedge clk); ext_raise_i = 1'b1; ext_st0_i = 8'h50;
    @(negedge clk); ext_raise_i = 1'b0;
    chk("R11 irq", int'(irq_o), 1);
    chk("R11 st0", int'(st0_o), 'h50);
    sense("R11 equip", 'h50, 0);
    sense("R11 then normal", 'h23, 0);
  endtask

  task automatic t_poll_cut();
    issue(3'd0, 2'd1, 1'b0, 8'd5);
    ctl_reset();
    sense("R2 first poll", 'hC0, 0);
    issue(3'd3, 2'd1, 1'b0, 8'd0);
    chk("R2 track cleared via step", int'(st0_o), 'h20);
    sense("R10 poll cut", 'h21, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_hw_reset();
    t_ctl_reset();
    t_seek();
    t_recal();
    t_step();
    t_ext();
    t_poll_cut();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule